// File: doc/BRIEF.md
# Chainable Active-Low Priority Encoder

This block resolves a bank of simultaneous requests into the binary index of the single request that outranks the others. A higher index always outranks a lower one. Requests and the index are carried active-low. Each stage is purely combinational and handles eight request lines. A stage reports whether any of its lines is active through a group flag. It also passes an enable downward when it holds no active request. Identical stages can therefore be chained so that an upper stage, whenever it has work, hides everything below it.

The top module chains `NUM_STAGES` stages of `STAGE_W` lines each, which by default makes a 16-request encoder. It builds the upper index bits from the stages' group flags, using a second, narrow instance of the same stage. It builds the lower index bits by AND-ing the stage codes, which works because an idle or disabled stage drives an all-high code. There is no clock, no storage and no flow control: the pins are plain levels, so the usual valid/ready rules do not apply.

Top module: `pe_cascade`

## Requirements
- R1: With `ena_n` low, the reported index is the position of the highest-numbered `req_n` bit that is low. Any lower-numbered low bits do not change the result.
- R2: The index is active-low: the value on `idx_n` is the bitwise inverse of the winning position. For example, position 0 reads as 4'hF and position 15 reads as 4'h0.
- R3: With `ena_n` low and at least one `req_n` bit low, `any_n` is low. This holds even when only bit 0 is low, so that case can be told apart from the case where nothing is requesting.
- R4: With `ena_n` low and every `req_n` bit high, `idx_n` is all ones and `any_n` is high.
- R5: With `ena_n` high, `idx_n` is all ones and both `any_n` and `eo_n` are high, whatever `req_n` holds.
- R6: `eo_n` is low exactly when `ena_n` is low and every `req_n` bit is high.
- R7: When any bit in the upper half (`req_n[15:8]`) is low, `idx_n[3]` is 0 and `idx_n[2:0]` comes from the upper half alone. The lower-half bits then have no effect on any output.
- R8: When the upper half is all high and the block is enabled, `idx_n[3]` is 1 and `idx_n[2:0]` encodes the highest active lower-half line.
- R9: `any_n` and `eo_n` are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ena_n | input | 1 | Enable for the whole chain, active-low |
| req_n | input | 16 | Request lines, active-low; bit 15 has the highest rank |
| idx_n | output | 4 | Index of the winning request, active-low |
| any_n | output | 1 | Low when the block is enabled and some request is active |
| eo_n | output | 1 | Low when the block is enabled and no request is active; enables a further lower chain |

## Verification
The bench targets several corner cases:
- Request 0 alone against no request at all. A design that drops the group flag gives the same all-ones index for both, and the two become indistinguishable.
- Requests that straddle the boundary between the two stages, such as lines 7 and 8 together. A design that does not suppress the lower stage merges both codes into a wrong index.
- The disabled state with every request active. A design that ignores the enable leaks a code or a group flag.
- Lower-half noise under an active upper line. A design whose cascade enable is wired the wrong way lets the lower half alter the index.

// File: rtl/pe_pkg.sv
package pe_pkg;
  function automatic int pe_idx_w(input int lanes);
    return (lanes <= 2) ? 1 : $clog2(lanes);
  endfunction
endpackage

// File: rtl/pe_msb_find.sv
module pe_msb_find
  import pe_pkg::*;
#(
  parameter int W  = 8,
  localparam int IW = pe_idx_w(W)
) (
  input  logic [W-1:0]  hot,
  output logic          hit,
  output logic [IW-1:0] pos
);
  always_comb begin
    pos = '0;
    hit = 1'b0;
    for (int k = 0; k < W; k++) begin
      if (hot[k]) begin
        pos = IW'(k);
        hit = 1'b1;
      end
    end
  end

  always_comb begin
    if (hit) begin
      a_r1_pos_is_set: assert (hot[pos] == 1'b1)
        else $error("found position not set");
      for (int k = 0; k < W; k++) begin
        if (k > int'(pos)) begin
          a_r1_nothing_above: assert (hot[k] == 1'b0)
            else $error("higher bit set above found position");
        end
      end
    end else begin
      a_r4_empty_vector: assert (hot == '0)
        else $error("miss reported on non-empty vector");
    end
  end
endmodule

// File: rtl/pe_stage.sv
module pe_stage
  import pe_pkg::*;
#(
  parameter int W  = 8,
  localparam int IW = pe_idx_w(W)
) (
  input  logic          en_in_n,
  input  logic [W-1:0]  din_n,
  output logic [IW-1:0] code_n,
  output logic          gs_n,
  output logic          en_out_n
);
  logic          hit;
  logic [IW-1:0] pos;

  pe_msb_find #(.W(W)) u_find (
    .hot (~din_n),
    .hit (hit),
    .pos (pos)
  );

  always_comb begin
    if (en_in_n) begin
      code_n   = '1;
      gs_n     = 1'b1;
      en_out_n = 1'b1;
    end else if (hit) begin
      code_n   = ~pos;
      gs_n     = 1'b0;
      en_out_n = 1'b1;
    end else begin
      code_n   = '1;
      gs_n     = 1'b1;
      en_out_n = 1'b0;
    end
  end

  always_comb begin
    if (en_in_n) begin
      a_r5_stage_quiet: assert (code_n == '1 && gs_n && en_out_n)
        else $error("disabled stage not quiet");
    end
    a_r9_stage_excl: assert (gs_n || en_out_n)
      else $error("group flag and enable-out both active");
    if (!gs_n) begin
      a_r1_stage_line_active: assert (din_n[~code_n] == 1'b0)
        else $error("coded line is not active");
    end
  end
endmodule

// File: rtl/pe_cascade.sv
module pe_cascade
  import pe_pkg::*;
#(
  parameter int STAGE_W    = 8,
  parameter int NUM_STAGES = 2,
  localparam int IW_S = pe_idx_w(STAGE_W),
  localparam int IW_G = pe_idx_w(NUM_STAGES),
  localparam int IW   = IW_S + IW_G,
  localparam int N    = STAGE_W * NUM_STAGES
) (
  input  logic          ena_n,
  input  logic [N-1:0]  req_n,
  output logic [IW-1:0] idx_n,
  output logic          any_n,
  output logic          eo_n
);
  logic [NUM_STAGES:0]   chain_n;
  logic [NUM_STAGES-1:0] gs_s;
  logic [IW_S-1:0]       code_s [NUM_STAGES];
  logic [IW_S-1:0]       low_bits_n;
  logic [IW_G-1:0]       grp_code_n;
  logic                  grp_eo_n;

  assign chain_n[NUM_STAGES] = ena_n;

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    pe_stage #(.W(STAGE_W)) u_stage (
      .en_in_n  (chain_n[s+1]),
      .din_n    (req_n[s*STAGE_W +: STAGE_W]),
      .code_n   (code_s[s]),
      .gs_n     (gs_s[s]),
      .en_out_n (chain_n[s])
    );
  end

  always_comb begin
    low_bits_n = '1;
    for (int s = 0; s < NUM_STAGES; s++) begin
      low_bits_n = low_bits_n & code_s[s];
    end
  end

  pe_stage #(.W(NUM_STAGES)) u_group (
    .en_in_n  (1'b0),
    .din_n    (gs_s),
    .code_n   (grp_code_n),
    .gs_n     (any_n),
    .en_out_n (grp_eo_n)
  );

  assign idx_n = {grp_code_n, low_bits_n};
  assign eo_n  = chain_n[0];

  always_comb begin
    a_r3_any_matches_req: assert (any_n == (ena_n || (req_n == '1)))
      else $error("group flag disagrees with requests");
    a_r6_eo_matches_idle: assert (eo_n == !(!ena_n && (req_n == '1)))
      else $error("enable-out disagrees with idle state");
    a_r9_top_excl: assert (any_n || eo_n)
      else $error("any_n and eo_n both low");
    if (!eo_n) begin
      a_r4_idle_group: assert (!grp_eo_n && idx_n == '1)
        else $error("idle chain shows a code");
    end
    if (!any_n) begin
      a_r2_index_active: assert (req_n[~idx_n] == 1'b0)
        else $error("reported index not requesting");
    end
  end
endmodule

// File: tb/pe_cascade_tb.sv
module pe_cascade_tb;
  logic        clk = 1'b0;
  logic        ena_n;
  logic [15:0] req_n;
  logic [3:0]  idx_n;
  logic        any_n;
  logic        eo_n;
  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  always #2.5 clk = ~clk;

  pe_cascade u_dut (
    .ena_n (ena_n),
    .req_n (req_n),
    .idx_n (idx_n),
    .any_n (any_n),
    .eo_n  (eo_n)
  );

  // {ena_n, req_n, idx_n, any_n, eo_n}
  localparam logic [22:0] VEC [12] = '{
    {1'b0, 16'hFFFF, 4'hF, 1'b1, 1'b0},
    {1'b0, 16'hFFFE, 4'hF, 1'b0, 1'b1},
    {1'b0, 16'h7FFF, 4'h0, 1'b0, 1'b1},
    {1'b0, 16'h0000, 4'h0, 1'b0, 1'b1},
    {1'b0, 16'hFEFF, 4'h7, 1'b0, 1'b1},
    {1'b0, 16'hFF7F, 4'h8, 1'b0, 1'b1},
    {1'b0, 16'hFE00, 4'h7, 1'b0, 1'b1},
    {1'b1, 16'h0000, 4'hF, 1'b1, 1'b1},
    {1'b1, 16'hFFFF, 4'hF, 1'b1, 1'b1},
    {1'b0, 16'hFFF5, 4'hC, 1'b0, 1'b1},
    {1'b0, 16'hEFFE, 4'h3, 1'b0, 1'b1},
    {1'b0, 16'hFF00, 4'h8, 1'b0, 1'b1}
  };

  function automatic logic [5:0] model(input logic en, input logic [15:0] r);
    logic [3:0] pos;
    logic       hit;
    pos = 4'h0;
    hit = 1'b0;
    for (int k = 0; k < 16; k++) begin
      if (!r[k]) begin
        pos = 4'(k);
        hit = 1'b1;
      end
    end
    if (en) return {4'hF, 1'b1, 1'b1};
    if (!hit) return {4'hF, 1'b1, 1'b0};
    return {~pos, 1'b0, 1'b1};
  endfunction

  task automatic check(input string tag, input logic [5:0] exp);
    checks++;
    if ({idx_n, any_n, eo_n} !== exp) begin
      failures++;
      $display("FAIL %s ena_n=%b req_n=%h actual idx_n=%h any_n=%b eo_n=%b expected idx_n=%h any_n=%b eo_n=%b",
               tag, ena_n, req_n, idx_n, any_n, eo_n, exp[5:2], exp[1], exp[0]);
    end
    if (!any_n && !eo_n) begin
      failures++;
      $display("FAIL R9 any_n and eo_n both low: actual 0/0 expected not both 0");
    end
  endtask

  task automatic apply(input logic en, input logic [15:0] r);
    @(negedge clk);
    ena_n = en;
    req_n = r;
    #1;
  endtask

  initial begin
    #400000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    logic [5:0]  ref_out;
    ena_n = 1'b1;
    req_n = 16'hFFFF;
    #1;
    check("R5 initial disabled", 6'b1111_11);

    for (int i = 0; i < 12; i++) begin
      apply(VEC[i][22], VEC[i][21:6]);
      if (VEC[i][22])                  check("R5 table", VEC[i][5:0]);
      else if (VEC[i][21:6] == 16'hFFFF) check("R4 R6 table", VEC[i][5:0]);
      else                              check("R1 R2 R3 table", VEC[i][5:0]);
    end

    // R8: full sweep of the lower stage, upper idle
    for (int p = 0; p < 256; p++) begin
      apply(1'b0, {8'hFF, 8'(p)});
      check("R8 lower sweep", model(1'b0, {8'hFF, 8'(p)}));
    end

    // R7: full sweep of the upper stage, lower held with noise
    for (int p = 0; p < 255; p++) begin
      apply(1'b0, {8'(p), 8'h5A});
      check("R7 upper sweep", model(1'b0, {8'(p), 8'h5A}));
      apply(1'b0, {8'(p), 8'h00});
      check("R7 upper sweep lower busy", model(1'b0, {8'(p), 8'h5A}));
    end

    // R5: disabled ignores every pattern
    for (int p = 0; p < 64; p++) begin
      apply(1'b1, 16'(p * 1021));
      check("R5 disabled", 6'b1111_11);
    end

    // R1 R6: random sample of the cascaded pair
    lfsr = 16'hACE1;
    for (int i = 0; i < 2000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      apply(lfsr[3] & lfsr[9] & lfsr[0], lfsr ^ {lfsr[7:0], lfsr[15:8]});
      ref_out = model(ena_n, req_n);
      check("R1 R6 random", ref_out);
    end

    // R3: request 0 alone vs nothing
    apply(1'b0, 16'hFFFE);
    check("R3 line zero", 6'b1111_01);
    apply(1'b0, 16'hFFFF);
    check("R4 idle", 6'b1111_10);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule